// File: doc/BRIEF.md
# Machine-Mode Trap Entry and Return Unit

This unit handles the path into and out of machine-mode exception handlers for a simple in-order core. Each cycle the core may present one retiring instruction word with its PC. The unit decodes two cases from that word:
- the return-from-trap instruction;
- a CSRRW aimed at a read-only CSR, which is an illegal instruction.

For either case it raises a redirect in the same cycle and supplies the PC that fetch must go to next. At the following clock edge it updates its state: the current privilege level and the interrupt-enable and previous-privilege fields of the status register. On trap entry it also updates the exception PC and the cause.

Two parameters set the variant: the register width (32 or 64) and whether user mode is built in. The return instruction writes the lowest supported privilege into the previous-privilege field. That value is user when user mode exists and machine otherwise. A CSRRW to a read-only CSR traps even when the source register is x0, because CSRRW always performs a write. Two plain write strobes let the core set the trap vector and the status fields.

Top module: `mtrap_unit`

## Requirements
- R1: After reset, priv = 2'b11 (machine), mstatus holds only MPP = 2'b11 in bits 12:11 with MIE (bit 3) and MPIE (bit 7) clear, mepc, mcause and mtvec are zero, and redirect is low.
- R2: A valid instruction with opcode 7'h73, funct3 3'b001 (CSRRW) and CSR address bits 31:30 equal to 2'b11 (read-only space, e.g. 0xC00) is illegal for any rs1, including x0; in the same cycle redirect is high and redirect_pc equals mtvec.
- R3: At the edge after an illegal instruction, mepc takes its PC with bits 1:0 cleared, mcause becomes 2, priv becomes 2'b11, MPP takes the old priv, MPIE takes the old MIE, and MIE clears.
- R4: A valid word 32'h30200073 (mret) raises redirect in the same cycle, with redirect_pc equal to mepc, not mepc + 4.
- R5: At the edge after mret, priv takes the old MPP, MIE takes the old MPIE, MPIE sets, and MPP becomes 2'b00 when user mode is built in and 2'b11 otherwise.
- R6: CSRRW to a CSR whose address bits 11:10 are not 2'b11, other CSR instructions to read-only CSRs (e.g. CSRRS), and all other instructions cause no redirect and leave all state unchanged.
- R7: A mtvec write stores csr_wdata with bits 1:0 forced to zero (direct mode).
- R8: A mstatus write loads MIE from bit 3 and MPIE from bit 7. It loads MPP from bits 12:11 only if the value is a supported level (2'b11, or 2'b00 with user mode); otherwise MPP keeps its value.
- R9: With instr_valid low, no instruction word causes a redirect or changes any state.
- R10: When a trap or mret occurs in the same cycle as a mstatus write, the trap or mret update wins and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | instr and pc describe a retiring instruction |
| instr | input | 32 | Instruction word |
| pc | input | XLEN | Address of instr |
| mtvec_we | input | 1 | Write csr_wdata into the trap vector |
| mstatus_we | input | 1 | Write csr_wdata into the status fields |
| csr_wdata | input | XLEN | Write data for both strobes |
| redirect | output | 1 | Fetch must jump to redirect_pc |
| redirect_pc | output | XLEN | Next fetch address on redirect |
| priv | output | 2 | Current privilege level |
| mstatus | output | XLEN | Status register (MIE, MPIE, MPP) |
| mepc | output | XLEN | Saved PC of the trapping instruction |
| mcause | output | XLEN | Trap cause |
| mtvec | output | XLEN | Trap handler base |

## Verification
The assertions assume that pc is word-aligned on valid instructions and that mtvec holds a handler address before the first trap. They also assume that mret is issued only with a meaningful saved state, so the restored privilege matches a level the build supports. The stimulus programs the trap vector and status fields through the write strobes before any trap. It uses only aligned PCs and mixes traps, returns, benign CSR accesses and idle cycles. A second instance with 64-bit width and no user mode receives the same stimulus, which covers both legal previous-privilege encodings.

// File: rtl/mtrap_unit.sv
module mtrap_unit #(
  parameter int XLEN     = 32,
  parameter bit HAS_USER = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] pc,
  input  logic            mtvec_we,
  input  logic            mstatus_we,
  input  logic [XLEN-1:0] csr_wdata,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_pc,
  output logic [1:0]      priv,
  output logic [XLEN-1:0] mstatus,
  output logic [XLEN-1:0] mepc,
  output logic [XLEN-1:0] mcause,
  output logic [XLEN-1:0] mtvec
);

  localparam logic [1:0]      PRV_M     = 2'b11;
  localparam logic [1:0]      PRV_U     = 2'b00;
  localparam logic [1:0]      LOWEST    = HAS_USER ? PRV_U : PRV_M;
  localparam logic [6:0]      OP_SYSTEM = 7'h73;
  localparam logic [2:0]      F3_CSRRW  = 3'b001;
  localparam logic [31:0]     MRET_WORD = 32'h3020_0073;
  localparam logic [XLEN-1:0] ALIGN     = {{(XLEN-2){1'b1}}, 2'b00};
  localparam logic [XLEN-1:0] CAUSE_ILL = XLEN'(2);
  localparam int              B_MIE     = 3;
  localparam int              B_MPIE    = 7;
  localparam int              B_MPP     = 11;

  logic       mie, mpie;
  logic [1:0] mpp;

  wire is_ro_write = instr[6:0] == OP_SYSTEM && instr[14:12] == F3_CSRRW
                     && instr[31:30] == 2'b11;
  wire take_trap   = instr_valid && is_ro_write;
  wire take_mret   = instr_valid && instr == MRET_WORD;

  wire [1:0] wr_mpp    = csr_wdata[B_MPP+1:B_MPP];
  wire       wr_mpp_ok = wr_mpp == PRV_M || (HAS_USER && wr_mpp == PRV_U);

  assign redirect    = take_trap || take_mret;
  assign redirect_pc = take_trap ? mtvec : mepc;

  always_comb begin
    mstatus              = '0;
    mstatus[B_MIE]       = mie;
    mstatus[B_MPIE]      = mpie;
    mstatus[B_MPP+1:B_MPP] = mpp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv   <= PRV_M;
      mie    <= 1'b0;
      mpie   <= 1'b0;
      mpp    <= PRV_M;
      mepc   <= '0;
      mcause <= '0;
    end else if (take_trap) begin
      priv   <= PRV_M;
      mpp    <= priv;
      mpie   <= mie;
      mie    <= 1'b0;
      mepc   <= pc & ALIGN;
      mcause <= CAUSE_ILL;
    end else if (take_mret) begin
      priv   <= mpp;
      mie    <= mpie;
      mpie   <= 1'b1;
      mpp    <= LOWEST;
    end else if (mstatus_we) begin
      mie  <= csr_wdata[B_MIE];
      mpie <= csr_wdata[B_MPIE];
      if (wr_mpp_ok) mpp <= wr_mpp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mtvec <= '0;
    else if (mtvec_we) mtvec <= csr_wdata & ALIGN;
  end

  // R3
  trap_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |=> priv == PRV_M && mcause == CAUSE_ILL && !mie
                  && mepc == ($past(pc) & ALIGN) && mpp == $past(priv)
                  && mpie == $past(mie));

  // R5
  mret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_mret && !take_trap |=> priv == $past(mpp) && mie == $past(mpie)
                                && mpie && mpp == LOWEST);

  // R8
  mpp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mpp == PRV_M || (HAS_USER && mpp == PRV_U));

  // R5
  priv_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    priv == PRV_M || (HAS_USER && priv == PRV_U));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid && !mstatus_we |=> $stable(mstatus) && $stable(priv)
                                   && $stable(mepc) && $stable(mcause));

  // R2
  redirect_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect && !take_mret |-> redirect_pc == mtvec);

endmodule

// File: tb/mtrap_unit_test.sv
module mtrap_unit_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] instr;
    logic [31:0] pc;
    logic        redir;
    logic [31:0] rpc;
    logic [1:0]  priv;
    logic [31:0] mst;
    logic [31:0] mepc;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{32'hC000_1073, 32'h2000, 1'b1, 32'h4000, 2'b11, 32'h1880, 32'h2000},
    '{32'h3020_0073, 32'h4000, 1'b1, 32'h2000, 2'b11, 32'h0088, 32'h2000},
    '{32'h0000_0013, 32'h2004, 1'b0, 32'h0,    2'b11, 32'h0088, 32'h2000},
    '{32'h3020_0073, 32'h2008, 1'b1, 32'h2000, 2'b00, 32'h0088, 32'h2000},
    '{32'hC000_92F3, 32'h300C, 1'b1, 32'h4000, 2'b11, 32'h0080, 32'h300C},
    '{32'hC000_22F3, 32'h4000, 1'b0, 32'h0,    2'b11, 32'h0080, 32'h300C},
    '{32'h3400_9073, 32'h4004, 1'b0, 32'h0,    2'b11, 32'h0080, 32'h300C},
    '{32'h3020_0073, 32'h4008, 1'b1, 32'h300C, 2'b00, 32'h0088, 32'h300C},
    '{32'hC820_1073, 32'h3010, 1'b1, 32'h4000, 2'b11, 32'h0080, 32'h3010}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic instr_valid = 1'b0, mtvec_we = 1'b0, mstatus_we = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] pc = '0, wdata = '0;

  logic        redirect, m_redirect;
  logic [31:0] redirect_pc, mstatus, mepc, mcause, mtvec;
  logic [63:0] m_redirect_pc, m_mstatus, m_mepc, m_mcause, m_mtvec;
  logic [1:0]  priv, m_priv;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mtrap_unit #(.XLEN(32), .HAS_USER(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .pc(pc[31:0]), .mtvec_we(mtvec_we), .mstatus_we(mstatus_we),
    .csr_wdata(wdata[31:0]), .redirect(redirect), .redirect_pc(redirect_pc),
    .priv(priv), .mstatus(mstatus), .mepc(mepc), .mcause(mcause), .mtvec(mtvec));

  mtrap_unit #(.XLEN(64), .HAS_USER(1'b0)) uut_m (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .pc(pc), .mtvec_we(mtvec_we), .mstatus_we(mstatus_we),
    .csr_wdata(wdata), .redirect(m_redirect), .redirect_pc(m_redirect_pc),
    .priv(m_priv), .mstatus(m_mstatus), .mepc(m_mepc), .mcause(m_mcause),
    .mtvec(m_mtvec));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic csr_write(bit tvec, logic [63:0] d);
    @(negedge clk);
    mtvec_we = tvec; mstatus_we = !tvec; wdata = d;
    @(negedge clk);
    mtvec_we = 1'b0; mstatus_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2);
    // R1 reset state
    check("R1 priv", {62'b0, priv}, 64'h3);
    check("R1 mstatus", {32'b0, mstatus}, 64'h1800);
    check("R1 mepc/mcause/mtvec", {32'b0, mepc | mcause | mtvec}, 64'h0);
    check("R1 redirect", {63'b0, redirect}, 64'h0);
    check("R1 64b mstatus", m_mstatus, 64'h1800);
    @(negedge clk); rst_n = 1'b1;

    // R7 mtvec alignment
    csr_write(1'b1, 64'h4003);
    check("R7 mtvec", {32'b0, mtvec}, 64'h4000);
    check("R7 64b mtvec", m_mtvec, 64'h4000);
    csr_write(1'b0, 64'h1808);
    check("R8 mstatus", {32'b0, mstatus}, 64'h1808);

    // R2 R3 R4 R5 R6 table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      instr = VEC[i].instr; pc = {32'b0, VEC[i].pc}; instr_valid = 1'b1;
      #1;
      check("R2/R4/R6 redirect", {63'b0, redirect}, {63'b0, VEC[i].redir});
      check("R2/R4/R6 64b redirect", {63'b0, m_redirect}, {63'b0, VEC[i].redir});
      if (VEC[i].redir) begin
        check("R2/R4 redirect_pc", {32'b0, redirect_pc}, {32'b0, VEC[i].rpc});
        check("R2/R4 64b redirect_pc", m_redirect_pc, {32'b0, VEC[i].rpc});
      end
      @(negedge clk);
      instr_valid = 1'b0;
      check("R3/R5/R6 priv", {62'b0, priv}, {62'b0, VEC[i].priv});
      check("R3/R5/R6 mstatus", {32'b0, mstatus}, {32'b0, VEC[i].mst});
      check("R3/R6 mepc", {32'b0, mepc}, {32'b0, VEC[i].mepc});
      check("R5 64b machine-only priv", {62'b0, m_priv}, 64'h3);
      check("R5 64b machine-only mstatus", m_mstatus, {32'b0, VEC[i].mst | 32'h1800});
      check("R3 64b mepc", m_mepc, {32'b0, VEC[i].mepc});
    end
    check("R3 mcause", {32'b0, mcause}, 64'h2);
    check("R3 64b mcause", m_mcause, 64'h2);

    // R8 unsupported MPP ignored
    csr_write(1'b0, 64'h0808);
    check("R8 bad MPP kept", {32'b0, mstatus}, 64'h0008);
    check("R8 64b bad MPP kept", m_mstatus, 64'h1808);
    csr_write(1'b0, 64'h0000);
    check("R8 MPP user accepted", {32'b0, mstatus}, 64'h0000);
    check("R8 64b MPP user rejected", m_mstatus, 64'h1800);

    // R10 trap beats status write
    @(negedge clk);
    instr = 32'hC000_1073; pc = 64'h5000; instr_valid = 1'b1;
    mstatus_we = 1'b1; wdata = 64'h1888;
    @(negedge clk);
    instr_valid = 1'b0; mstatus_we = 1'b0;
    check("R10 mstatus", {32'b0, mstatus}, 64'h1800);
    check("R10 64b mstatus", m_mstatus, 64'h1800);
    check("R10 mepc", {32'b0, mepc}, 64'h5000);

    // R9 invalid instruction ignored
    @(negedge clk);
    instr = 32'hC000_1073; pc = 64'h6000; instr_valid = 1'b0;
    #1;
    check("R9 redirect", {63'b0, redirect}, 64'h0);
    @(negedge clk);
    check("R9 mepc", {32'b0, mepc}, 64'h5000);
    check("R9 mstatus", {32'b0, mstatus}, 64'h1800);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule